// File: doc/BRIEF.md
# GPIO Interrupt Line Router

This block turns a wide bank of general-purpose inputs into a small set of interrupt requests. Each of its eight request lines picks one of 62 input pins through a 7-bit source code, passes that pin through a two-stage synchroniser, and conditions it as a level, single-edge or dual-edge trigger. One global enable bit gates all eight lines. The pins are grouped on the chip as follows: 0 to 12, 13 to 19, 20 to 36, 37 to 49 and 50 to 61. The router treats them as one flat index space.

Software sets the block up through five 32-bit words on a simple register bus. The bus has a byte address, write data, a write strobe and a read-data return that is registered one cycle after the address is presented. One word holds the per-line trigger fields and the global enable. Four words each hold two source codes. The eight outputs are registered and go straight to a downstream interrupt controller.

Top module: `gpio_irq_router`

## Requirements
- R1: After synchronous reset every register reads zero and all eight outputs are low.
- R2: The word at byte address 0x00 holds polarity in bits 7:0, single-edge enables in bits 15:8, dual-edge enables in bits 23:16 and the global enable in bit 31. Bit n of each field belongs to line n. Bits 30:24 read as zero. Read data appears on the cycle after the address is presented.
- R3: Source codes for line n live in the word at 0x04 + 4*(n/2). Even lines use bits 6:0 and odd lines use bits 22:16. All other bits of those words read as zero. Addresses above 0x10 read as zero and ignore writes.
- R4: While the global enable is 0, all outputs are low one cycle after the enable is cleared.
- R5: With both edge bits of a line clear, the output follows the selected pin three clock edges after the pin changes. It is inverted when the polarity bit is 1.
- R6: With single-edge set and dual-edge clear, polarity 0 gives a one-cycle pulse on a rising pin and polarity 1 gives one on a falling pin. The opposite transition gives no pulse.
- R7: With dual-edge set, every pin transition gives a one-cycle pulse, whatever the single-edge and polarity bits are.
- R8: A source code of 62 or above keeps its line low in every mode, including inverted level mode.
- R9: Writing a new source code never by itself produces an edge pulse, even when the new pin's level differs from the old one.
- R10: Any line can select any pin from 0 to 61, including the highest line and the highest pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| gpio_in | input | 62 | Asynchronous input pins |
| irq_out | output | 8 | Conditioned interrupt requests |

## Verification
A source-code write and an edge detection can land on the same clock edge. A write can also place a line on a pin whose level differs from the pin it leaves. The bench provokes this by parking the new pin high and the old pin low, then rewriting the code while the line is in rising-edge mode. It then requires the outputs to stay low for the following cycles. It also requires a genuine transition on the new pin to give exactly one pulse afterwards, so a missing previous-value reload shows up as a false pulse.

// File: rtl/gir_pkg.sv
package gir_pkg;
  typedef enum logic [1:0] {
    TRIG_LEVEL  = 2'd0,
    TRIG_SINGLE = 2'd1,
    TRIG_BOTH   = 2'd2
  } trig_mode_e;

  // dual-edge wins over single-edge, single-edge wins over level
  function automatic trig_mode_e pick_mode(input logic dual, input logic single);
    if (dual)        return TRIG_BOTH;
    else if (single) return TRIG_SINGLE;
    else             return TRIG_LEVEL;
  endfunction
endpackage

// File: rtl/gir_sync.sv
module gir_sync #(
  parameter int W      = 62,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gir_regs.sv
module gir_regs #(
  parameter int N_LINES = 8,
  parameter int SEL_W   = 7,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic [DATA_W-1:0]               reg_wdata,
  input  logic                            reg_we,
  output logic [DATA_W-1:0]               reg_rdata,
  output logic [N_LINES-1:0]              pol,
  output logic [N_LINES-1:0]              single,
  output logic [N_LINES-1:0]              dual,
  output logic                            en,
  output logic [N_LINES-1:0][SEL_W-1:0]   sel,
  output logic [N_LINES-1:0][SEL_W-1:0]   sel_new,
  output logic [N_LINES-1:0]              sel_load
);
  localparam int IDX_W      = ADDR_W - 2;
  localparam int POL_LSB    = 0;
  localparam int SINGLE_LSB = 8;
  localparam int DUAL_LSB   = 16;
  localparam int EN_BIT     = 31;
  localparam int ODD_LSB    = 16;
  localparam int N_SEL_REGS = (N_LINES + 1) / 2;

  logic [IDX_W-1:0] idx;
  logic             ctrl_wr;
  logic [DATA_W-1:0] rd_word;

  assign idx     = reg_addr[ADDR_W-1:2];
  assign ctrl_wr = reg_we && (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pol    <= '0;
      single <= '0;
      dual   <= '0;
      en     <= 1'b0;
    end else if (ctrl_wr) begin
      pol    <= reg_wdata[POL_LSB +: N_LINES];
      single <= reg_wdata[SINGLE_LSB +: N_LINES];
      dual   <= reg_wdata[DUAL_LSB +: N_LINES];
      en     <= reg_wdata[EN_BIT];
    end
  end

  for (genvar n = 0; n < N_LINES; n++) begin : g_sel
    localparam int LSB = (n % 2 == 1) ? ODD_LSB : 0;
    assign sel_load[n] = reg_we && (idx == IDX_W'(1 + n / 2));
    assign sel_new[n]  = reg_wdata[LSB +: SEL_W];

    always_ff @(posedge clk) begin
      if (rst)              sel[n] <= '0;
      else if (sel_load[n]) sel[n] <= sel_new[n];
    end
  end

  always_comb begin
    rd_word = '0;
    if (idx == '0) begin
      rd_word[POL_LSB +: N_LINES]    = pol;
      rd_word[SINGLE_LSB +: N_LINES] = single;
      rd_word[DUAL_LSB +: N_LINES]   = dual;
      rd_word[EN_BIT]                = en;
    end
    for (int n = 0; n < N_LINES; n++) begin
      if (idx == IDX_W'(1 + n / 2)) begin
        if (n % 2 == 1) rd_word[ODD_LSB +: SEL_W] = sel[n];
        else            rd_word[0 +: SEL_W]       = sel[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_word;
  end

  a_r2_resv_zero: assert property (@(posedge clk) disable iff (rst)
    (idx == '0) |=> (reg_rdata[30:24] == '0));

  a_r3_sel_pad_zero: assert property (@(posedge clk) disable iff (rst)
    ((idx >= IDX_W'(1)) && (idx <= IDX_W'(N_SEL_REGS))) |=>
      (reg_rdata[DATA_W-1:ODD_LSB+SEL_W] == '0) && (reg_rdata[ODD_LSB-1:SEL_W] == '0));
endmodule

// File: rtl/gir_line.sv
module gir_line
  import gir_pkg::*;
#(
  parameter int N_GPIO = 62,
  parameter int SEL_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_GPIO-1:0] pins_sync,
  input  logic [SEL_W-1:0]  sel,
  input  logic [SEL_W-1:0]  sel_new,
  input  logic              sel_load,
  input  logic              en,
  input  logic              pol,
  input  logic              single,
  input  logic              dual,
  output logic              irq
);
  localparam int PAD = 1 << SEL_W;

  logic [PAD-1:0] padded;
  logic           valid;
  logic           cur;
  logic           prev;
  logic           rise;
  logic           trig;
  trig_mode_e     mode;

  // codes beyond the last pin land on zero padding
  assign padded = PAD'(pins_sync);
  assign valid  = (int'(sel) < N_GPIO);
  assign cur    = padded[sel];
  assign rise   = cur & ~prev;
  assign mode   = pick_mode(dual, single);

  always_comb begin
    unique case (mode)
      TRIG_BOTH:   trig = cur ^ prev;
      TRIG_SINGLE: trig = pol ? (prev & ~cur) : rise;
      default:     trig = cur ^ pol;
    endcase
  end

  // a new source reloads the history so the switch itself is no edge
  always_ff @(posedge clk) begin
    if (rst)           prev <= 1'b0;
    else if (sel_load) prev <= padded[sel_new];
    else               prev <= cur;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= en & valid & trig;
  end

  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);

  a_r8_bad_code_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !irq);

  a_r6_rise_once: assert property (@(posedge clk) disable iff (rst)
    (rise && !sel_load) |=> !rise);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int N_GPIO  = 62,
  parameter int N_LINES = 8,
  parameter int SEL_W   = 7,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               reg_we,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [N_GPIO-1:0]  gpio_in,
  output logic [N_LINES-1:0] irq_out
);
  logic [N_LINES-1:0]            pol, single, dual, sel_load;
  logic                          en;
  logic [N_LINES-1:0][SEL_W-1:0] sel, sel_new;
  logic [N_GPIO-1:0]             pins_sync;

  gir_regs #(
    .N_LINES(N_LINES), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata),
    .pol(pol), .single(single), .dual(dual), .en(en),
    .sel(sel), .sel_new(sel_new), .sel_load(sel_load)
  );

  gir_sync #(.W(N_GPIO), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(gpio_in), .q(pins_sync)
  );

  for (genvar n = 0; n < N_LINES; n++) begin : g_line
    gir_line #(.N_GPIO(N_GPIO), .SEL_W(SEL_W)) u_line (
      .clk(clk), .rst(rst),
      .pins_sync(pins_sync),
      .sel(sel[n]), .sel_new(sel_new[n]), .sel_load(sel_load[n]),
      .en(en), .pol(pol[n]), .single(single[n]), .dual(dual[n]),
      .irq(irq_out[n])
    );
  end
endmodule

// File: tb/gpio_irq_router_test.sv
module gpio_irq_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic [61:0] gpio_in = '0;
  logic [7:0]  irq_out;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  typedef struct {
    int        at;
    logic [7:0] val;
    string     tag;
  } item_t;
  item_t sb[$];

  gpio_irq_router uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .gpio_in(gpio_in), .irq_out(irq_out)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare scheduled output expectations
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      item_t it;
      it = sb.pop_front();
      vectors++;
      if (irq_out !== it.val) begin
        fails++;
        $display("FAIL %s: irq_out=%b expected=%b (cycle %0d)", it.tag, irq_out, it.val, cyc);
      end
    end
  end

  task automatic expect_irq(input int dly, input logic [7:0] v, input string tag);
    item_t it;
    it.at = cyc + dly; it.val = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a;
    @(negedge clk);
    vectors++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h", tag, reg_rdata, exp);
    end
  endtask

  task automatic pin(input int i, input logic v);
    @(negedge clk); gpio_in[i] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_chk(5'h00, 32'h0, "R1");
    rd_chk(5'h04, 32'h0, "R1");
    expect_irq(0, 8'h00, "R1");
    idle(1);
    // R2 control word fields and reserved bits
    wr(5'h00, 32'hFFFF_FFFF);
    rd_chk(5'h00, 32'h80FF_FFFF, "R2");
    wr(5'h00, 32'h0);
    // R3 selector packing and unmapped words
    wr(5'h04, 32'hFFFF_FFFF);
    rd_chk(5'h04, 32'h007F_007F, "R3");
    wr(5'h14, 32'hFFFF_FFFF);
    rd_chk(5'h14, 32'h0, "R3");
    rd_chk(5'h00, 32'h0, "R3");
    // level mode setup: line0 pin0, line1 pin61, others invalid
    wr(5'h04, 32'h003D_0000);
    wr(5'h08, 32'h007F_007F);
    wr(5'h0C, 32'h007F_007F);
    wr(5'h10, 32'h007F_007F);
    wr(5'h00, 32'h8000_0000);
    idle(4);
    expect_irq(0, 8'h00, "R5");
    pin(0, 1'b1); expect_irq(2, 8'h00, "R5"); expect_irq(3, 8'h01, "R5");
    idle(4);
    pin(61, 1'b1); expect_irq(3, 8'h03, "R5");
    idle(4);
    wr(5'h00, 32'h8000_0002); expect_irq(1, 8'h01, "R5");
    idle(2);
    // R4 global enable off
    wr(5'h00, 32'h0000_0002); expect_irq(1, 8'h00, "R4");
    pin(0, 1'b0); expect_irq(3, 8'h00, "R4");
    pin(0, 1'b1);
    idle(5);
    // R8 invalid code in inverted level mode
    wr(5'h04, 32'h003D_007F);
    wr(5'h00, 32'h8000_0001); expect_irq(1, 8'h02, "R8");
    idle(3);
    // R6 single edge
    gpio_in = '0;
    wr(5'h04, 32'h003D_0000);
    wr(5'h00, 32'h8000_0302);
    idle(5);
    expect_irq(0, 8'h00, "R6");
    pin(0, 1'b1);  expect_irq(3, 8'h01, "R6"); expect_irq(4, 8'h00, "R6");
    idle(5);
    pin(61, 1'b1); expect_irq(3, 8'h00, "R6"); expect_irq(4, 8'h00, "R6");
    idle(5);
    pin(61, 1'b0); expect_irq(3, 8'h02, "R6"); expect_irq(4, 8'h00, "R6");
    idle(5);
    pin(0, 1'b0);  expect_irq(3, 8'h00, "R6"); expect_irq(4, 8'h00, "R6");
    idle(5);
    // R7 dual edge overrides single and polarity
    wr(5'h00, 32'h8001_0101);
    idle(2);
    pin(0, 1'b1); expect_irq(3, 8'h01, "R7"); expect_irq(4, 8'h00, "R7");
    idle(5);
    pin(0, 1'b0); expect_irq(3, 8'h01, "R7"); expect_irq(4, 8'h00, "R7");
    idle(5);
    // R9 source switch to a high pin makes no pulse
    wr(5'h00, 32'h8000_0100);
    pin(5, 1'b1);
    idle(5);
    wr(5'h04, 32'h003D_0005);
    expect_irq(1, 8'h00, "R9"); expect_irq(2, 8'h00, "R9"); expect_irq(3, 8'h00, "R9");
    idle(5);
    pin(5, 1'b0); expect_irq(3, 8'h00, "R9");
    idle(5);
    pin(5, 1'b1); expect_irq(3, 8'h01, "R9"); expect_irq(4, 8'h00, "R9");
    idle(5);
    // R10 highest line on highest pin, level mode
    wr(5'h04, 32'h007F_007F);
    wr(5'h10, 32'h003D_007F);
    rd_chk(5'h10, 32'h003D_007F, "R10");
    wr(5'h00, 32'h8000_0000);
    idle(3);
    expect_irq(0, 8'h00, "R10");
    pin(61, 1'b1); expect_irq(3, 8'h80, "R10");
    idle(4);
    pin(61, 1'b0); expect_irq(3, 8'h00, "R10");
    idle(6);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails + sb.size());
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected=finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule